// File: doc/BRIEF.md
# Low-Power Stop Wake Controller

This block sequences a device into and out of a low-power stop mode. When a stop is commanded while running, it freezes the current 3-bit interrupt priority mask and a clock-gating selection into internal registers. It then drops the enables for the core clock, the watchdog clock and the bus, halt and spurious-interrupt monitors. Depending on the frozen selection, it also drops the system clock enable. Clock generation lives elsewhere; this block only produces enables.

Two request sources are arbitrated continuously: an internal periodic-timer request and an external request, each carried as a 3-bit level where zero means no request. The higher level wins. On equal levels the timer wins. While stopped, the winner wakes the device only if its level is strictly above the frozen mask, or if it is level 7, which is treated as non-maskable. A wake raises a one-cycle pulse and restores every enable in that same cycle. Reset also ends stop mode at once, without a wake pulse.

The state machine has three states. `ST_RUN` is normal operation. `ST_STOP` is the stopped state. `ST_WAKE` is the one-cycle exit state. It has four transitions:
- enter: `ST_RUN` to `ST_STOP` on `stop_cmd`.
- rouse: `ST_STOP` to `ST_WAKE` when a qualifying request is present.
- resume: `ST_WAKE` to `ST_RUN`, unconditionally.
- abort: any state to `ST_RUN` on reset.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is in the running state: `stopped`=0 and `wake_pulse`=0, and all of `core_clk_en`, `sys_clk_en`, `wdog_clk_en`, `bus_mon_en`, `halt_mon_en` and `spur_mon_en` are 1.
- R2: `stop_cmd`=1 sampled at a clock edge while running makes `stopped`=1, `core_clk_en`=0 and `wdog_clk_en`=0 from that edge until the stop ends.
- R3: While stopped, `sys_clk_en` equals the inverse of `gate_all_cfg` as sampled at the stop-entry edge. Later changes of `gate_all_cfg` have no effect until the next entry.
- R4: `bus_mon_en`, `halt_mon_en` and `spur_mon_en` are 0 exactly while `stopped`=1 and are 1 otherwise.
- R5: The mask used for the wake decision is `cur_mask` sampled at the stop-entry edge. Changing `cur_mask` while stopped does not change which requests wake the device.
- R6: While stopped, a winning request of level L wakes the device if L > frozen mask, or if L = 7. Otherwise the device stays stopped.
- R7: A wake condition seen at an edge makes `wake_pulse`=1 for exactly the next cycle. In that cycle `stopped`=0 and all enables are 1. The block is then running again.
- R8: `win_src` and `win_lvl` reflect the current request inputs combinationally. The encoding is `win_src` 0 = none, 1 = timer, 2 = external. The higher nonzero level wins, and on equal nonzero levels the timer wins. A level of 0 is no request, and when neither source requests, `win_lvl`=0.
- R9: Asserting reset while stopped returns the block to the running state of R1 without a wake pulse.
- R10: `stop_cmd` is ignored in the wake cycle: the block returns to running and `stopped` stays 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset, also ends stop |
| stop_cmd | input | 1 | Request to enter stop mode |
| cur_mask | input | 3 | Current interrupt priority mask |
| gate_all_cfg | input | 1 | 1: also gate the system clock while stopped |
| tmr_lvl | input | 3 | Periodic-timer request level (0 = none) |
| ext_lvl | input | 3 | External request level (0 = none) |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| bus_mon_en | output | 1 | Bus monitor enable |
| halt_mon_en | output | 1 | Halt monitor enable |
| spur_mon_en | output | 1 | Spurious-interrupt monitor enable |
| stopped | output | 1 | Block is in the stop state |
| wake_pulse | output | 1 | One-cycle wake indication |
| win_src | output | 2 | Arbitration winner: 0 none, 1 timer, 2 external |
| win_lvl | output | 3 | Level of the winning request |

## Verification
The bench targets ties between the two sources, a level-7 request against a frozen mask of 7, and a request at exactly the frozen mask level. A design with the tie going the wrong way reports the external source. A design that applies the mask inclusively wakes too early, or never wakes on the non-maskable level. Raising or lowering `cur_mask` and toggling `gate_all_cfg` during a stop exposes a design that reads the live values instead of the frozen ones: it wakes at the wrong moment or gates the system clock wrongly. Reset in mid-stop and a stop command held through the wake cycle catch designs that emit a stray pulse or re-enter stop at once.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int LVL_W  = 3;
    localparam int SRC_W  = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAKE = 2'd2
    } swc_state_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_EXT  = 2'd2
    } swc_src_t;

    localparam lvl_t LVL_NMI = '1;

endpackage

// File: rtl/swc_arbiter.sv
module swc_arbiter
    import swc_pkg::*;
(
    input  lvl_t     tmr_lvl,
    input  lvl_t     ext_lvl,
    output swc_src_t src,
    output lvl_t     lvl
);

    logic tmr_req;
    logic ext_req;
    logic tmr_wins;

    assign tmr_req  = (tmr_lvl != '0);
    assign ext_req  = (ext_lvl != '0);
    // Timer takes equal levels; zero is never a request.
    assign tmr_wins = tmr_req && (tmr_lvl >= ext_lvl);

    always_comb begin
        if (tmr_wins) begin
            src = SRC_TMR;
            lvl = tmr_lvl;
        end else if (ext_req) begin
            src = SRC_EXT;
            lvl = ext_lvl;
        end else begin
            src = SRC_NONE;
            lvl = '0;
        end
    end

    always_comb begin
        // R8
        if (tmr_req && (tmr_lvl == ext_lvl)) begin
            tie_to_timer_chk: assert (src == SRC_TMR);
        end
        // R8
        if (!tmr_req && !ext_req) begin
            idle_no_winner_chk: assert (src == SRC_NONE && lvl == '0);
        end
    end

endmodule

// File: rtl/swc_entry_latch.sv
module swc_entry_latch
    import swc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  lvl_t mask_in,
    input  logic cfg_in,
    output lvl_t mask_q,
    output logic cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            cfg_q  <= 1'b0;
        end else if (capture) begin
            mask_q <= mask_in;
            cfg_q  <= cfg_in;
        end
    end

    // R5
    frozen_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(mask_q) && $stable(cfg_q));

endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_cmd,
    input  lvl_t frozen_mask,
    input  logic frozen_cfg,
    input  lvl_t win_lvl,
    output logic entering,
    output logic core_clk_en,
    output logic sys_clk_en,
    output logic wdog_clk_en,
    output logic mon_en,
    output logic stopped,
    output logic wake_pulse
);

    swc_state_t state_q;
    swc_state_t state_d;
    logic       qualifies;

    // Strictly above the frozen mask, or the non-maskable top level.
    assign qualifies = (win_lvl != '0) &&
                       ((win_lvl > frozen_mask) || (win_lvl == LVL_NMI));
    assign entering  = (state_q == ST_RUN) && stop_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop_cmd)  state_d = ST_STOP;
            ST_STOP: if (qualifies) state_d = ST_WAKE;
            ST_WAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        core_clk_en = 1'b1;
        sys_clk_en  = 1'b1;
        wdog_clk_en = 1'b1;
        mon_en      = 1'b1;
        stopped     = 1'b0;
        wake_pulse  = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_STOP: begin
                core_clk_en = 1'b0;
                sys_clk_en  = ~frozen_cfg;
                wdog_clk_en = 1'b0;
                mon_en      = 1'b0;
                stopped     = 1'b1;
            end
            ST_WAKE: wake_pulse = 1'b1;
            default: ;
        endcase
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse && !stopped);

    // R7
    wake_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(stopped));

    // R2
    stop_gates_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !core_clk_en && !wdog_clk_en && !mon_en);

    // R6
    no_early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && (win_lvl <= frozen_mask) && (win_lvl != LVL_NMI) |=> stopped);

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_cmd,
    input  logic [2:0] cur_mask,
    input  logic       gate_all_cfg,
    input  logic [2:0] tmr_lvl,
    input  logic [2:0] ext_lvl,
    output logic       core_clk_en,
    output logic       sys_clk_en,
    output logic       wdog_clk_en,
    output logic       bus_mon_en,
    output logic       halt_mon_en,
    output logic       spur_mon_en,
    output logic       stopped,
    output logic       wake_pulse,
    output logic [1:0] win_src,
    output logic [2:0] win_lvl
);

    swc_src_t arb_src;
    lvl_t     arb_lvl;
    lvl_t     frozen_mask;
    logic     frozen_cfg;
    logic     entering;
    logic     mon_en;

    swc_arbiter u_arb (
        .tmr_lvl (tmr_lvl),
        .ext_lvl (ext_lvl),
        .src     (arb_src),
        .lvl     (arb_lvl)
    );

    swc_entry_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (entering),
        .mask_in (cur_mask),
        .cfg_in  (gate_all_cfg),
        .mask_q  (frozen_mask),
        .cfg_q   (frozen_cfg)
    );

    swc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_cmd    (stop_cmd),
        .frozen_mask (frozen_mask),
        .frozen_cfg  (frozen_cfg),
        .win_lvl     (arb_lvl),
        .entering    (entering),
        .core_clk_en (core_clk_en),
        .sys_clk_en  (sys_clk_en),
        .wdog_clk_en (wdog_clk_en),
        .mon_en      (mon_en),
        .stopped     (stopped),
        .wake_pulse  (wake_pulse)
    );

    assign bus_mon_en  = mon_en;
    assign halt_mon_en = mon_en;
    assign spur_mon_en = mon_en;
    assign win_src     = arb_src;
    assign win_lvl     = arb_lvl;

    // R4
    monitors_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !bus_mon_en && !halt_mon_en && !spur_mon_en);

    // R3
    sys_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> (sys_clk_en == !$past(gate_all_cfg)));

endmodule

// File: tb/stop_wake_ctrl_test.sv
`timescale 1ns/1ps
module stop_wake_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stop_cmd;
    logic [2:0] cur_mask;
    logic       gate_all_cfg;
    logic [2:0] tmr_lvl;
    logic [2:0] ext_lvl;
    logic       core_clk_en, sys_clk_en, wdog_clk_en;
    logic       bus_mon_en, halt_mon_en, spur_mon_en;
    logic       stopped, wake_pulse;
    logic [1:0] win_src;
    logic [2:0] win_lvl;

    int n_checks = 0;
    int n_errors = 0;

    // bench model: 0 run, 1 stop, 2 wake
    int       m_st;
    bit [2:0] m_mask;
    bit       m_cfg;

    always #2.5 clk = ~clk;

    stop_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .cur_mask(cur_mask),
        .gate_all_cfg(gate_all_cfg), .tmr_lvl(tmr_lvl), .ext_lvl(ext_lvl),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
        .wdog_clk_en(wdog_clk_en), .bus_mon_en(bus_mon_en),
        .halt_mon_en(halt_mon_en), .spur_mon_en(spur_mon_en),
        .stopped(stopped), .wake_pulse(wake_pulse),
        .win_src(win_src), .win_lvl(win_lvl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_src(input int t, input int e);
        if (t != 0 && t >= e) return 1;
        if (e != 0) return 2;
        return 0;
    endfunction

    function automatic int exp_lvl(input int t, input int e);
        if (t != 0 && t >= e) return t;
        return e;
    endfunction

    function automatic bit exp_wake(input int l, input int msk);
        return (l != 0) && ((l > msk) || (l == 7));
    endfunction

    task automatic check_all();
        bit st = (m_st == 1);
        check(win_src == 2'(exp_src(tmr_lvl, ext_lvl)), "R8 src", win_src, exp_src(tmr_lvl, ext_lvl));
        check(win_lvl == 3'(exp_lvl(tmr_lvl, ext_lvl)), "R8 lvl", win_lvl, exp_lvl(tmr_lvl, ext_lvl));
        check(stopped == st, "R2 stopped", stopped, st);
        check(core_clk_en == !st && wdog_clk_en == !st, "R2 core/wdog en",
              {core_clk_en, wdog_clk_en}, {!st, !st});
        check(sys_clk_en == !(st && m_cfg), "R3 sys en", sys_clk_en, !(st && m_cfg));
        check(bus_mon_en == !st && halt_mon_en == !st && spur_mon_en == !st, "R4 monitors",
              {bus_mon_en, halt_mon_en, spur_mon_en}, {3{!st}});
        check(wake_pulse == (m_st == 2), "R6 R7 wake pulse", wake_pulse, (m_st == 2));
    endtask

    task automatic step(input bit sc, input int msk, input bit cfg, input int t, input int e);
        @(negedge clk);
        stop_cmd = sc; cur_mask = 3'(msk); gate_all_cfg = cfg;
        tmr_lvl = 3'(t); ext_lvl = 3'(e);
        #1 check_all();
        @(posedge clk);
        case (m_st)
            0: if (sc) begin m_st = 1; m_mask = 3'(msk); m_cfg = cfg; end
            1: if (exp_wake(exp_lvl(t, e), m_mask)) m_st = 2;
            default: m_st = 0;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_st = 0; m_mask = 0; m_cfg = 0;
        #1;
        // R1 and R9: running state right after reset
        check(!stopped && !wake_pulse, "R1 R9 reset state", {stopped, wake_pulse}, 0);
        check(core_clk_en && sys_clk_en && wdog_clk_en && bus_mon_en && halt_mon_en && spur_mon_en,
              "R1 reset enables", {core_clk_en, sys_clk_en, wdog_clk_en}, 7);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0c41;
        void'($urandom(seed));
        rst_n = 1'b0; stop_cmd = 0; cur_mask = 0; gate_all_cfg = 0; tmr_lvl = 0; ext_lvl = 0;
        m_st = 0; m_mask = 0; m_cfg = 0;
        do_reset();

        // R8 ties and zero levels at run time
        step(0, 0, 0, 4, 4);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 5);
        step(0, 0, 0, 3, 6);

        // R6: non-maskable level 7 against mask 7, R3 with gating all
        step(1, 7, 1, 0, 0);
        step(0, 7, 0, 6, 6);
        step(0, 0, 0, 0, 7);
        step(0, 0, 0, 0, 0);

        // R5: request equal to frozen mask stays asleep despite lowered live mask
        step(1, 4, 0, 0, 0);
        step(0, 0, 1, 4, 0);
        step(0, 0, 1, 0, 4);
        step(0, 0, 1, 5, 2);
        // R10: stop_cmd held during the wake cycle is ignored
        step(1, 0, 0, 0, 0);
        check(!stopped, "R10 stop ignored in wake", stopped, 0);
        step(0, 0, 0, 0, 0);

        // R9: reset in the middle of a stop
        step(1, 6, 1, 0, 0);
        step(0, 6, 1, 2, 3);
        do_reset();
        step(0, 0, 0, 0, 0);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            bit sc  = ($urandom % 6) == 0;
            int msk = $urandom % 8;
            bit cfg = $urandom % 2;
            int t   = (($urandom % 4) == 0) ? int'($urandom % 8) : 0;
            int e   = (($urandom % 4) == 0) ? int'($urandom % 8) : 0;
            step(sc, msk, cfg, t, e);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule